// File: doc/BRIEF.md
# Dual-Domain Serial Port Enable Register

This block is the enable register for one serial audio port that has separate transmit and receive sections. The host writes one 32-bit word on a single write strobe. That word holds two five-bit groups of active-high enables, one group per direction. Each group is carried into the serial clock domain of its own direction through a two-flop synchronizer and held there. The held values drive five functions in each direction: a bit-clock divider, a high-frequency clock divider, a serializer run enable, a state machine run enable and a frame sync generator.

The read port does not return what the host wrote. It returns the values held in the two serial domains, brought back through a second two-flop synchronizer in the host domain. After a write, software polls the read port until the value it wrote appears. Only then does it know that the serial side has taken the change. Both serial clocks must be running for a write to take effect.

Each direction has two dividers, both fed by that direction's serial clock. Each divider has its own 5-bit ratio input. A frame sync generator emits a one-cycle pulse at a fixed period of serial clocks. That period is set by a parameter.

Top module: `serport_gate_ctl`

## Requirements
- R1: After reset, `rd_data` reads 0, both enable vectors are 0, both frame sync outputs are low and every divider output follows its serial clock.
- R2: Transmit enables sit in bits 12..8 and receive enables in bits 4..0. Within each group, the bit at offset 4 enables the frame sync generator, offset 3 the state machine, offset 2 the serializer, offset 1 the high-frequency divider and offset 0 the bit-clock divider. The `tx_en_o`/`rx_en_o` vectors use the same offsets. A write changes only the outputs whose bits it changes.
- R3: Bits 31..13 and 7..5 always read as 0, and writing ones to them changes no output.
- R4: Each group reaches its enable outputs through two flops clocked by that direction's serial clock. `rd_data` shows the serial-domain values after two further host clock edges, so a read on the host cycle right after a write still returns the old value.
- R5: A divider whose enable is 0, or whose ratio is 0, passes its serial clock through unchanged.
- R6: A divider with its enable at 1 and ratio N > 0 produces a period of N+1 serial clocks. The output is high for floor((N+1)/2) of those clocks, which gives an even duty cycle for even division.
- R7: While its enable is 1, a frame sync output pulses high for exactly one serial clock, once every `FS_PERIOD` serial clocks. While its enable is 0 it stays low.
- R8: When a frame sync enable rises, its counter restarts. The first pulse comes on the serial edge after the enable is held, not at a phase left over from an earlier run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_host | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset, all domains |
| wr_en | input | 1 | Write strobe, one host cycle |
| wr_data | input | 32 | Write word |
| rd_data | output | 32 | Readback of the serial-domain held enables |
| tx_sclk | input | 1 | Transmit serial clock |
| tx_hclk_ratio | input | 5 | Transmit high-frequency divider ratio |
| tx_bclk_ratio | input | 5 | Transmit bit-clock divider ratio |
| rx_sclk | input | 1 | Receive serial clock |
| rx_hclk_ratio | input | 5 | Receive high-frequency divider ratio |
| rx_bclk_ratio | input | 5 | Receive bit-clock divider ratio |
| tx_en_o | output | 5 | Transmit enables held in the transmit domain |
| rx_en_o | output | 5 | Receive enables held in the receive domain |
| tx_hclk_o | output | 1 | Transmit high-frequency divider output |
| tx_bclk_o | output | 1 | Transmit bit-clock divider output |
| tx_fs_o | output | 1 | Transmit frame sync pulse |
| rx_hclk_o | output | 1 | Receive high-frequency divider output |
| rx_bclk_o | output | 1 | Receive bit-clock divider output |
| rx_fs_o | output | 1 | Receive frame sync pulse |

## Verification
The assertions rely on three conditions on the inputs:

- The synchronizer checks expect no host write to land on the same instant as a serial clock edge, so that the two-cycle delay is exact in simulation.
- The divider counter-bound check applies only while a ratio input is held steady.
- The frame sync width check assumes `FS_PERIOD` is at least 2.

The stimulus meets these conditions. It runs the three clocks at unrelated periods with offset phases, changes ratios only while the matching divider is disabled or between measurements, and keeps the default period of 16.

// File: rtl/serport_gate_pkg.sv
package serport_gate_pkg;
  localparam int REG_W   = 32;
  localparam int GRP_W   = 5;
  localparam int TX_LSB  = 8;
  localparam int RX_LSB  = 0;
  // offsets inside one direction group
  localparam int F_BDIV  = 0;
  localparam int F_HDIV  = 1;
  localparam int F_SER   = 2;
  localparam int F_SM    = 3;
  localparam int F_FS    = 4;
  localparam int N_DIV   = 2;
endpackage

// File: rtl/serport_bit_sync.sv
module serport_bit_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;

  // R4
  sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q == $past(d, 2));
endmodule

// File: rtl/serport_clkdiv.sv
module serport_clkdiv #(
  parameter int RATIO_W = 5
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic               en,
  input  logic [RATIO_W-1:0] ratio,
  output logic               clk_out
);
  logic               run;
  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] cnt_nxt;
  logic [RATIO_W:0]   half;
  logic               lvl_q;

  assign run     = en && (ratio != '0);
  assign cnt_nxt = (cnt_q >= ratio) ? '0 : cnt_q + 1'b1;
  assign half    = ({1'b0, ratio} + 1'b1) >> 1;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= ratio;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      lvl_q <= ({1'b0, cnt_nxt} < half);
    end
  end

  assign clk_out = run ? lvl_q : clk_in;

  // R6
  cnt_bound_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (run && $stable(ratio)) |-> (cnt_q <= ratio));
  // R5
  div_idle_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    !run |=> !lvl_q);
endmodule

// File: rtl/serport_fsync.sv
module serport_fsync #(
  parameter int PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic fs
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic          fs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fs_q  <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      fs_q  <= 1'b0;
    end else begin
      fs_q  <= (cnt_q == '0);
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign fs = fs_q;

  // R7
  fs_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs |=> !fs);
  // R7
  fs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !fs);
endmodule

// File: rtl/serport_dir_ctl.sv
module serport_dir_ctl
  import serport_gate_pkg::*;
#(
  parameter int RATIO_W   = 5,
  parameter int FS_PERIOD = 16
) (
  input  logic               sclk,
  input  logic               rst_n,
  input  logic [GRP_W-1:0]   grp_host,
  input  logic [RATIO_W-1:0] hclk_ratio,
  input  logic [RATIO_W-1:0] bclk_ratio,
  output logic [GRP_W-1:0]   en_lat,
  output logic               hclk_out,
  output logic               bclk_out,
  output logic               fs_out
);
  logic [N_DIV-1:0]   div_out;
  logic [RATIO_W-1:0] div_ratio [N_DIV];

  assign div_ratio[0] = bclk_ratio;
  assign div_ratio[1] = hclk_ratio;

  serport_bit_sync #(.W(GRP_W)) u_in_sync (
    .clk   (sclk),
    .rst_n (rst_n),
    .d     (grp_host),
    .q     (en_lat)
  );

  for (genvar g = 0; g < N_DIV; g++) begin : g_div
    serport_clkdiv #(.RATIO_W(RATIO_W)) u_div (
      .clk_in  (sclk),
      .rst_n   (rst_n),
      .en      (en_lat[F_BDIV + g]),
      .ratio   (div_ratio[g]),
      .clk_out (div_out[g])
    );
  end

  assign bclk_out = div_out[0];
  assign hclk_out = div_out[1];

  serport_fsync #(.PERIOD(FS_PERIOD)) u_fs (
    .clk   (sclk),
    .rst_n (rst_n),
    .en    (en_lat[F_FS]),
    .fs    (fs_out)
  );
endmodule

// File: rtl/serport_gate_ctl.sv
module serport_gate_ctl
  import serport_gate_pkg::*;
#(
  parameter int RATIO_W   = 5,
  parameter int FS_PERIOD = 16
) (
  input  logic               clk_host,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  input  logic               tx_sclk,
  input  logic [RATIO_W-1:0] tx_hclk_ratio,
  input  logic [RATIO_W-1:0] tx_bclk_ratio,
  input  logic               rx_sclk,
  input  logic [RATIO_W-1:0] rx_hclk_ratio,
  input  logic [RATIO_W-1:0] rx_bclk_ratio,
  output logic [GRP_W-1:0]   tx_en_o,
  output logic [GRP_W-1:0]   rx_en_o,
  output logic               tx_hclk_o,
  output logic               tx_bclk_o,
  output logic               tx_fs_o,
  output logic               rx_hclk_o,
  output logic               rx_bclk_o,
  output logic               rx_fs_o
);
  logic [GRP_W-1:0] tx_host_q, rx_host_q;
  logic [GRP_W-1:0] tx_back, rx_back;
  logic             unused_rsvd;

  assign unused_rsvd = ^{wr_data[REG_W-1:TX_LSB+GRP_W],
                         wr_data[TX_LSB-1:RX_LSB+GRP_W]};

  always_ff @(posedge clk_host or negedge rst_n) begin
    if (!rst_n) begin
      tx_host_q <= '0;
      rx_host_q <= '0;
    end else if (wr_en) begin
      tx_host_q <= wr_data[TX_LSB +: GRP_W];
      rx_host_q <= wr_data[RX_LSB +: GRP_W];
    end
  end

  serport_dir_ctl #(.RATIO_W(RATIO_W), .FS_PERIOD(FS_PERIOD)) u_tx (
    .sclk       (tx_sclk),
    .rst_n      (rst_n),
    .grp_host   (tx_host_q),
    .hclk_ratio (tx_hclk_ratio),
    .bclk_ratio (tx_bclk_ratio),
    .en_lat     (tx_en_o),
    .hclk_out   (tx_hclk_o),
    .bclk_out   (tx_bclk_o),
    .fs_out     (tx_fs_o)
  );

  serport_dir_ctl #(.RATIO_W(RATIO_W), .FS_PERIOD(FS_PERIOD)) u_rx (
    .sclk       (rx_sclk),
    .rst_n      (rst_n),
    .grp_host   (rx_host_q),
    .hclk_ratio (rx_hclk_ratio),
    .bclk_ratio (rx_bclk_ratio),
    .en_lat     (rx_en_o),
    .hclk_out   (rx_hclk_o),
    .bclk_out   (rx_bclk_o),
    .fs_out     (rx_fs_o)
  );

  serport_bit_sync #(.W(GRP_W)) u_tx_back (
    .clk   (clk_host),
    .rst_n (rst_n),
    .d     (tx_en_o),
    .q     (tx_back)
  );

  serport_bit_sync #(.W(GRP_W)) u_rx_back (
    .clk   (clk_host),
    .rst_n (rst_n),
    .d     (rx_en_o),
    .q     (rx_back)
  );

  always_comb begin
    rd_data = '0;
    rd_data[TX_LSB +: GRP_W] = tx_back;
    rd_data[RX_LSB +: GRP_W] = rx_back;
  end

  // R4
  rd_stale_chk: assert property (@(posedge clk_host) disable iff (!rst_n)
    $rose(wr_en) |=> $stable(rd_data));
endmodule

// File: tb/serport_gate_ctl_tb.sv
module serport_gate_ctl_tb_top;
  localparam int FSP = 16;

  logic        clk_host = 1'b0, tx_sclk = 1'b0, rx_sclk = 1'b0;
  logic        rst_n = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic [4:0]  tx_hr = '0, tx_br = '0, rx_hr = '0, rx_br = '0;
  logic [4:0]  tx_en, rx_en;
  logic        tx_h, tx_b, tx_fs, rx_h, rx_b, rx_fs;
  int          n_chk = 0, n_fail = 0;
  logic [2:0]  psel = '0;
  logic        pout, pclk;

  always #10 clk_host = ~clk_host;
  initial begin #3; forever #7 tx_sclk = ~tx_sclk; end
  initial begin #5; forever #13 rx_sclk = ~rx_sclk; end

  serport_gate_ctl #(.RATIO_W(5), .FS_PERIOD(FSP)) dut_i (
    .clk_host(clk_host), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tx_sclk(tx_sclk), .tx_hclk_ratio(tx_hr),
    .tx_bclk_ratio(tx_br), .rx_sclk(rx_sclk), .rx_hclk_ratio(rx_hr),
    .rx_bclk_ratio(rx_br), .tx_en_o(tx_en), .rx_en_o(rx_en),
    .tx_hclk_o(tx_h), .tx_bclk_o(tx_b), .tx_fs_o(tx_fs),
    .rx_hclk_o(rx_h), .rx_bclk_o(rx_b), .rx_fs_o(rx_fs)
  );

  always_comb begin
    case (psel)
      3'd0: pout = tx_h;
      3'd1: pout = tx_b;
      3'd2: pout = rx_h;
      3'd3: pout = rx_b;
      3'd4: pout = tx_fs;
      default: pout = rx_fs;
    endcase
    pclk = (psel == 3'd0 || psel == 3'd1 || psel == 3'd4) ? tx_sclk : rx_sclk;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [31:0] v);
    @(negedge clk_host);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk_host);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic poll_rd(input logic [31:0] exp, input string tag);
    logic [31:0] seen = '0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_host);
      seen = rd_data;
      if (seen == exp) break;
    end
    chk(seen == exp, tag, seen, exp);
  endtask

  task automatic measure(input logic [2:0] sel, input int per, input int hi, input string tag);
    bit s [64];
    int r1, r2, h;
    psel = sel;
    for (int i = 0; i < 64; i++) begin
      @(negedge pclk);
      s[i] = pout;
    end
    r1 = -1; r2 = -1;
    for (int i = 0; i < 63; i++) begin
      if (!s[i] && s[i+1]) begin
        if (r1 < 0) r1 = i; else if (r2 < 0) r2 = i;
      end
    end
    h = 0;
    if (r1 >= 0 && r2 > r1) for (int i = r1 + 1; i <= r2; i++) h += s[i];
    chk(r2 - r1 == per, {tag, " period"}, r2 - r1, per);
    chk(h == hi, {tag, " high"}, h, hi);
  endtask

  // R1 R5: reset state
  task automatic t_reset();
    @(negedge clk_host);
    chk(rd_data == 0, "R1 rd_data", rd_data, 0);
    chk(tx_en == 0 && rx_en == 0, "R1 enables", {tx_en, rx_en}, 0);
    chk(!tx_fs && !rx_fs, "R1 fs", {tx_fs, rx_fs}, 0);
    @(posedge tx_sclk); #2;
    chk(tx_h && tx_b, "R1 R5 tx bypass high", {tx_h, tx_b}, 3);
    @(negedge tx_sclk); #2;
    chk(!tx_h && !tx_b, "R1 R5 tx bypass low", {tx_h, tx_b}, 0);
    @(posedge rx_sclk); #2;
    chk(rx_h && rx_b, "R1 R5 rx bypass high", {rx_h, rx_b}, 3);
  endtask

  // R4 R2: stale readback then transmit group lands
  task automatic t_tx_group();
    host_write(32'h0000_0A00);
    @(negedge clk_host);
    chk(rd_data == 0, "R4 stale read", rd_data, 0);
    poll_rd(32'h0000_0A00, "R4 readback");
    chk(tx_en == 5'b01010, "R2 tx_en map", tx_en, 5'b01010);
    chk(rx_en == 0, "R2 rx untouched", rx_en, 0);
  endtask

  // R3: reserved bits
  task automatic t_reserved();
    host_write(32'hFFFF_E0E0);
    poll_rd(32'h0, "R3 reserved read zero");
    repeat (6) @(negedge clk_host);
    chk(rd_data == 0, "R3 rd stays zero", rd_data, 0);
    chk(tx_en == 0 && rx_en == 0, "R3 outputs zero", {tx_en, rx_en}, 0);
  endtask

  // R2: receive group
  task automatic t_rx_group();
    host_write(32'h0000_0015);
    poll_rd(32'h0000_0015, "R2 rx readback");
    chk(rx_en == 5'b10101, "R2 rx_en map", rx_en, 5'b10101);
    chk(tx_en == 0, "R2 tx untouched", tx_en, 0);
    host_write(32'h0);
    poll_rd(32'h0, "R2 clear");
  endtask

  // R6 R5: dividers
  task automatic t_div();
    tx_br = 5'd3; tx_hr = 5'd4; rx_br = 5'd1; rx_hr = 5'd6;
    host_write(32'h0000_0303);
    poll_rd(32'h0000_0303, "R6 div enable readback");
    measure(3'd1, 4, 2, "R6 tx bclk /4");
    measure(3'd0, 5, 2, "R6 tx hclk /5");
    measure(3'd3, 2, 1, "R6 rx bclk /2");
    measure(3'd2, 7, 3, "R6 rx hclk /7");
    rx_hr = 5'd0;
    repeat (3) @(posedge rx_sclk);
    @(posedge rx_sclk); #2;
    chk(rx_h == 1'b1, "R5 ratio0 high", rx_h, 1);
    @(negedge rx_sclk); #2;
    chk(rx_h == 1'b0, "R5 ratio0 low", rx_h, 0);
    host_write(32'h0);
    poll_rd(32'h0, "R5 disable readback");
    @(posedge tx_sclk); #2;
    chk(tx_b == 1'b1, "R5 disabled bypass", tx_b, 1);
  endtask

  // R7 R8: frame sync
  task automatic t_fsync();
    int first, cnt;
    host_write(32'h0000_1010);
    poll_rd(32'h0000_1010, "R7 fs readback");
    measure(3'd4, FSP, 1, "R7 tx fs");
    measure(3'd5, FSP, 1, "R7 rx fs");
    host_write(32'h0);
    poll_rd(32'h0, "R7 fs disable");
    psel = 3'd4; cnt = 0;
    for (int i = 0; i < 2 * FSP; i++) begin @(negedge tx_sclk); cnt += tx_fs; end
    chk(cnt == 0, "R7 no pulse while off", cnt, 0);
    host_write(32'h0000_1000);
    first = -1;
    for (int i = 0; i < FSP; i++) begin
      @(negedge tx_sclk);
      if (tx_fs && first < 0) first = i;
    end
    chk(first >= 0 && first <= 5, "R8 restart first pulse", first, 5);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk_host);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_host);
    t_reset();
    t_tx_group();
    t_reserved();
    t_rx_group();
    t_div();
    t_fsync();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule